// File: doc/BRIEF.md
# Masked Priority Interrupt Arbiter

This block decides, at each instruction boundary, whether the CPU takes an interrupt and which one. Its inputs are one non-maskable request pin and a parameterized set of maskable request lines. Each maskable line has its own enable. The block picks the single highest-priority eligible request. It then applies the global mask bit from the condition code register and reports the winner to the CPU entry sequencer as a one-cycle strobe with a source code.

The non-maskable pin is active low. A falling edge on it is captured in a latch that the sequencer clears with an acknowledge. The global mask has no effect on that latch. A hint from the decoder reports that the instruction just retired wrote the condition codes. At such a boundary nothing is accepted, and evaluation resumes at the next boundary.

The accept strobe is a plain control output with no ready and no back-pressure. The sequencer must take it in the cycle it is high. The maskable request lines are levels owned by the peripherals. A request that loses simply stays asserted and competes again at a later boundary.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `accept` is 0 and stays 0 until a boundary finds an eligible request.
- R2: A maskable source k counts only while both `src_req[k]` and `src_en[k]` are 1.
- R3: Priority is fixed. The non-maskable request ranks highest. Among maskable sources, a lower index wins. `accept_id` is 0 for the non-maskable request and k+1 for maskable source k.
- R4: A request that loses the priority scan is not dropped. If it is still asserted, it wins at a later boundary once the higher-priority requests are gone.
- R5: A pending non-maskable request is accepted whatever the value of `gmask`.
- R6: While `gmask` is 1, no maskable source is accepted. Once `gmask` returns to 0, the source is accepted at a later boundary if it is still present.
- R7: At a boundary where `ccr_write` is 1, nothing is accepted, not even the non-maskable request. Pending requests are evaluated at the next boundary.
- R8: Requests are evaluated only in a cycle with `boundary` high. The decision appears on `accept` and `accept_id` in the following cycle, as a pulse lasting exactly that one cycle.
- R9: A high-to-low transition on `nmi_n` sets the non-maskable pending latch. The latch stays set across boundaries until `nmi_ack` is high. Holding `nmi_n` low does not set it again. If a new falling edge and `nmi_ack` arrive in the same cycle, the set wins.
- R10: A boundary at which nothing is eligible produces no accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| nmi_ack | input | 1 | Sequencer clears the non-maskable latch |
| src_req | input | NSRC | Maskable request levels |
| src_en | input | NSRC | Per-source enables |
| gmask | input | 1 | Global mask bit from the condition code register |
| boundary | input | 1 | Instruction-boundary strobe |
| ccr_write | input | 1 | Retired instruction wrote the condition codes |
| accept | output | 1 | One-cycle accept strobe |
| accept_id | output | $clog2(NSRC+1) | Winner code: 0 = non-maskable, k+1 = source k |

## Verification
The bench drives a non-maskable edge while `gmask` is set. A design that let the mask reach the non-maskable path would stay silent there. It also places a pending edge on a condition-code-writing boundary, where a faulty design would accept despite the blocking hint. Other cases keep `nmi_n` low across several acknowledges to catch a level-triggered latch that re-fires. Further cases assert requests with their enables off, and raise two sources at once and then remove the winner. A wrong design would report a disabled or lower-ranked source, or lose the loser. Random traffic covers gaps between boundaries, where a design that samples off-boundary would pulse early.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_NMI  = 2'd1,
    WIN_SRC  = 2'd2
  } win_kind_e;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic ack,
  output logic pend
);
  logic prev_q;
  logic fall;

  assign fall = prev_q & ~nmi_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_q <= nmi_n;
      // a fresh edge outranks a clear in the same cycle
      pend   <= fall | (pend & ~ack);
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NSRC = 8,
  localparam int PW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] req,
  output logic            any,
  output logic [PW-1:0]   idx
);
  always_comb begin
    any = |req;
    idx = '0;
    // scan downward so the lowest set index is written last
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) idx = PW'(i);
    end
  end
endmodule

// File: rtl/irq_decide.sv
module irq_decide
  import irq_arb_pkg::*;
(
  input  logic      boundary,
  input  logic      ccr_write,
  input  logic      gmask,
  input  logic      nmi_pend,
  input  logic      src_any,
  output win_kind_e kind
);
  always_comb begin
    kind = WIN_NONE;
    if (boundary && !ccr_write) begin
      if (nmi_pend)               kind = WIN_NMI;
      else if (src_any && !gmask) kind = WIN_SRC;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int ID_W = $clog2(NSRC + 1),
  localparam int PW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_n,
  input  logic            nmi_ack,
  input  logic [NSRC-1:0] src_req,
  input  logic [NSRC-1:0] src_en,
  input  logic            gmask,
  input  logic            boundary,
  input  logic            ccr_write,
  output logic            accept,
  output logic [ID_W-1:0] accept_id
);
  logic            nmi_pend;
  logic [NSRC-1:0] live_req;
  logic            src_any;
  logic [PW-1:0]   src_idx;
  win_kind_e       kind;

  assign live_req = src_req & src_en;

  irq_nmi_latch u_nmi (
    .clk   (clk),
    .rst_n (rst_n),
    .nmi_n (nmi_n),
    .ack   (nmi_ack),
    .pend  (nmi_pend)
  );

  irq_prio_pick #(.NSRC(NSRC)) u_pick (
    .req (live_req),
    .any (src_any),
    .idx (src_idx)
  );

  irq_decide u_dec (
    .boundary  (boundary),
    .ccr_write (ccr_write),
    .gmask     (gmask),
    .nmi_pend  (nmi_pend),
    .src_any   (src_any),
    .kind      (kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept    <= 1'b0;
      accept_id <= '0;
    end else begin
      accept <= (kind != WIN_NONE);
      if (kind == WIN_NMI)      accept_id <= '0;
      else if (kind == WIN_SRC) accept_id <= ID_W'(src_idx) + ID_W'(1);
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int NSRC = 8,
  localparam int ID_W = $clog2(NSRC + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_req,
  input logic [NSRC-1:0] src_en,
  input logic            gmask,
  input logic            boundary,
  input logic            ccr_write,
  input logic            accept,
  input logic [ID_W-1:0] accept_id
);
  logic [NSRC-1:0] live_q;
  logic            gm_q, cw_q, bnd_q;
  logic            id_live, lower_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      gm_q   <= 1'b0;
      cw_q   <= 1'b0;
      bnd_q  <= 1'b0;
    end else begin
      live_q <= src_req & src_en;
      gm_q   <= gmask;
      cw_q   <= ccr_write;
      bnd_q  <= boundary;
    end
  end

  always_comb begin
    id_live    = 1'b0;
    lower_live = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (accept_id == ID_W'(i + 1)) id_live = live_q[i];
      if (ID_W'(i + 1) < accept_id)  lower_live = lower_live | live_q[i];
    end
  end

  assert_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> bnd_q);
  assert_ccr_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !cw_q);
  assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && accept_id != '0) |-> !gm_q);
  assert_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && accept_id != '0) |-> id_live);
  assert_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && accept_id != '0) |-> !lower_live);
  assert_id_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (accept_id <= ID_W'(NSRC)));
endmodule

bind irq_arbiter irq_arbiter_chk #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_req   (src_req),
  .src_en    (src_en),
  .gmask     (gmask),
  .boundary  (boundary),
  .ccr_write (ccr_write),
  .accept    (accept),
  .accept_id (accept_id)
);

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int IW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_n = 1'b1, nmi_ack = 1'b0;
  logic [N-1:0] src_req = '0, src_en = '0;
  logic gmask = 1'b0, boundary = 1'b0, ccr_write = 1'b0;
  logic accept;
  logic [IW-1:0] accept_id;

  int checks = 0, errors = 0;
  logic m_pend = 1'b0, m_prev = 1'b1;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_arbiter #(.NSRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .nmi_ack(nmi_ack),
    .src_req(src_req), .src_en(src_en), .gmask(gmask),
    .boundary(boundary), .ccr_write(ccr_write),
    .accept(accept), .accept_id(accept_id)
  );

  // expected decision: bit IW is accept, low bits the code
  function automatic logic [IW:0] expect_dec(logic pend, logic b, logic cw,
      logic gm, logic [N-1:0] rq, logic [N-1:0] en);
    logic [N-1:0] live = rq & en;
    if (!b || cw) return '0;
    if (pend) return {1'b1, {IW{1'b0}}};
    if (gm || live == '0) return '0;
    for (int i = 0; i < N; i++)
      if (live[i]) return {1'b1, IW'(i + 1)};
    return '0;
  endfunction

  task automatic step(input logic b, input logic cw, input logic gm,
      input logic [N-1:0] rq, input logic [N-1:0] en, input logic nn,
      input logic ack, input string tag);
    logic [IW:0] e;
    logic np;
    boundary = b; ccr_write = cw; gmask = gm; src_req = rq; src_en = en;
    nmi_n = nn; nmi_ack = ack;
    e  = expect_dec(m_pend, b, cw, gm, rq, en);
    np = (m_prev & ~nn) | (m_pend & ~ack);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (accept !== e[IW] || (e[IW] && accept_id !== e[IW-1:0])) begin
      errors++;
      $display("FAIL %s: accept=%0b id=%0d expected accept=%0b id=%0d",
               tag, accept, accept_id, e[IW], e[IW-1:0]);
    end
    m_pend = np;
    m_prev = nn;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] all_en = '1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (accept !== 1'b0) begin
      errors++;
      $display("FAIL R1: accept=%0b expected 0", accept);
    end
    step(1, 0, 0, '0, '0, 1, 0, "R1 idle after reset");
    step(1, 0, 0, 8'h00, all_en, 1, 0, "R10 nothing eligible");
    // R8: request present off-boundary gives no pulse
    step(0, 0, 0, 8'h10, all_en, 1, 0, "R8 no boundary");
    step(1, 0, 0, 8'h10, all_en, 1, 0, "R8 boundary accept id 5");
    step(0, 0, 0, 8'h10, all_en, 1, 0, "R8 single-cycle pulse");
    // R2: src3 disabled, src5 enabled -> id 6
    step(1, 0, 0, 8'h28, 8'hF7, 1, 0, "R2 disabled source ignored");
    step(1, 0, 0, 8'h08, 8'hF7, 1, 0, "R2 only disabled request");
    // R3/R4
    step(1, 0, 0, 8'h28, all_en, 1, 0, "R3 lower index wins");
    step(1, 0, 0, 8'h20, all_en, 1, 0, "R4 loser wins later");
    // R6
    step(1, 0, 1, 8'h04, all_en, 1, 0, "R6 masked held");
    step(1, 0, 0, 8'h04, all_en, 1, 0, "R6 unmasked accepted");
    // R5/R9: edge off-boundary, then boundary with mask set
    step(0, 0, 1, 8'h01, all_en, 0, 0, "R9 falling edge");
    step(1, 0, 1, 8'h01, all_en, 0, 0, "R5 nmi beats mask");
    step(1, 0, 0, 8'h01, all_en, 0, 0, "R9 stays pending without ack");
    // R7: ccr write blocks even the nmi
    step(1, 1, 0, 8'h01, all_en, 0, 0, "R7 ccr write blocks");
    step(1, 0, 0, 8'h01, all_en, 0, 1, "R7 resumes next boundary");
    step(1, 0, 0, 8'h01, all_en, 0, 0, "R9 low level no retrigger");
    step(0, 0, 0, 8'h00, all_en, 1, 0, "R9 release");
    // simultaneous fresh edge and ack: set wins
    step(0, 0, 0, 8'h00, all_en, 0, 1, "R9 edge with ack");
    step(1, 0, 1, 8'h00, all_en, 0, 1, "R9 set beat ack");
    step(1, 0, 0, 8'h02, all_en, 0, 0, "R9 cleared by ack");
    for (int n = 0; n < 4000; n++) begin
      logic b  = ($urandom % 2) == 0;
      logic cw = ($urandom % 5) == 0;
      logic gm = ($urandom % 2) == 0;
      logic nn = ($urandom % 8) != 0;
      logic ak = ($urandom % 6) == 0;
      logic [N-1:0] rq = N'($urandom) & N'($urandom);
      logic [N-1:0] en = N'($urandom) | N'($urandom);
      step(b, cw, gm, rq, en, nn, ak, "R3 R5 R6 R7 R8 random");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule